// File: doc/BRIEF.md
# ULPI PHY Control Register Bank

This block is the byte-wide register bank of a USB transceiver, reached through the register read and write commands that the ULPI bus handshake logic decodes. It holds three control registers: function, interface and OTG. It also holds two interrupt-enable registers, one for rising edges and one for falling edges. Each of these five registers is reached at three consecutive addresses. The first address overwrites the register. The second ORs the written byte in. The third clears the bits that are set in the written byte. The bank also offers fixed identification bytes, a read-only view of the five sampled status inputs, and a latch register that empties when it is read.

The status inputs are compared with their value at the previous clock edge. A transition is an event only when the enable bit for that bit and that direction is set. An event sets the matching latch bit and raises a one-cycle request to the bus logic to send a status update (RXCMD). The interrupt output is high while any latch bit is set. The address port is the full extended address. The immediate registers sit at its low end, and 2Fh is the escape code that the bus logic handles, so 2Fh holds no data in this bank.

Top module: `ulpi_regbank`

## Requirements
- R1: After reset, function control reads 41h, interface control 00h, OTG control 06h, both edge-enable registers 1Fh, the latch register 00h, and reg_rdata, irq_o and rxcmd_req_o are 0.
- R2: A write to a base address (04h function, 07h interface, 0Ah OTG, 0Dh rising enable, 10h falling enable) stores the byte under a per-register mask. The mask is 7Fh for function control (bit 7 is reserved and reads 0), 1Fh for the enable registers and FFh for the other two registers.
- R3: A write to base+1 ORs the masked byte into the register. A write to base+2 clears every register bit that is 1 in the byte.
- R4: Reading base, base+1 or base+2 returns the same register value. A read strobe at one clock edge puts the value on reg_rdata after that edge, and reg_rdata holds it until the next read strobe.
- R5: Addresses 00h to 03h read the vendor ID low byte, the vendor ID high byte, the product ID low byte and the product ID high byte, in that order. Writes to these addresses have no effect.
- R6: Address 13h reads the status inputs as sampled at the previous clock edge in bits [4:0], with bits [7:5] reading 0. Writes to 13h have no effect.
- R7: A 0-to-1 change of status bit n with rising-enable bit n set, or a 1-to-0 change with falling-enable bit n set, sets latch bit n. It also pulses rxcmd_req_o high for exactly one cycle, after the edge that first sees the new input value.
- R8: A transition whose enable bit is clear neither sets a latch bit nor raises rxcmd_req_o.
- R9: Reading 14h returns the latch (bits [7:5] read 0) and clears it. Writes to 14h have no effect. irq_o is 1 exactly while the latch is nonzero.
- R10: If an event occurs in the same cycle as a read of 14h, the read returns the old latch value and the latch bit of the new event stays set.
- R11: Addresses 15h to 2Eh, 2Fh and 30h to FFh read 00h, and writes to them change no register.
- R12: The first clock edge after reset only samples the status inputs. Inputs that are already high at that edge produce no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 8 | Extended register address |
| reg_wr | input | 1 | Write strobe for one cycle |
| reg_wdata | input | 8 | Write data |
| reg_rd | input | 1 | Read strobe for one cycle |
| reg_rdata | output | 8 | Registered read data |
| stat_in | input | 5 | Status inputs from the analog comparators and detectors |
| irq_o | output | 1 | Interrupt: a latch bit is set |
| rxcmd_req_o | output | 1 | One-cycle request to send a status update |

## Verification
A read of the latch register and a new enabled status transition can land on the same clock edge. The bench provokes this by raising a status bit at the same falling edge at which it asserts the read strobe for 14h. It judges the result by two things: the returned byte must hold only the bits latched before that edge, and a second read must show the new event's bit. A second same-cycle case is a read-clear of the latch while no event occurs. In that case the latch empties, and irq_o falls after the same edge.

// File: rtl/ulpi_rb_pkg.sv
package ulpi_rb_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 8;
  localparam int STAT_W = 5;
  localparam int NCTL   = 5;

  localparam logic [ADDR_W-1:0] ADR_STAT  = 8'h13;
  localparam logic [ADDR_W-1:0] ADR_LATCH = 8'h14;

  // control registers: function, interface, OTG, rising enable, falling enable
  localparam logic [ADDR_W-1:0] CTL_BASE [NCTL] = '{8'h04, 8'h07, 8'h0A, 8'h0D, 8'h10};
  localparam logic [DATA_W-1:0] CTL_RST  [NCTL] = '{8'h41, 8'h00, 8'h06, 8'h1F, 8'h1F};
  localparam logic [DATA_W-1:0] CTL_MASK [NCTL] = '{8'h7F, 8'hFF, 8'hFF, 8'h1F, 8'h1F};

  localparam int IDX_RISE = 3;
  localparam int IDX_FALL = 4;

  typedef enum logic [1:0] {ALIAS_PUT = 2'd0, ALIAS_SET = 2'd1, ALIAS_CLR = 2'd2, ALIAS_NONE = 2'd3} alias_e;
endpackage

// File: rtl/ulpi_rb_alias_reg.sv
module ulpi_rb_alias_reg
  import ulpi_rb_pkg::*;
#(
  parameter logic [ADDR_W-1:0] BASE  = 8'h04,
  parameter logic [DATA_W-1:0] RSTV  = 8'h00,
  parameter logic [DATA_W-1:0] MASK  = 8'hFF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              hit,
  output logic [DATA_W-1:0] q
);
  logic [ADDR_W-1:0] off;
  alias_e            kind;

  always_comb begin
    off = addr - BASE;
    hit = (off < ADDR_W'(3));
    unique case (off[1:0])
      2'd0:    kind = ALIAS_PUT;
      2'd1:    kind = ALIAS_SET;
      2'd2:    kind = ALIAS_CLR;
      default: kind = ALIAS_NONE;
    endcase
    if (!hit) kind = ALIAS_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= RSTV;
    end else if (wr_en) begin
      case (kind)
        ALIAS_PUT: q <= wdata & MASK;
        ALIAS_SET: q <= q | (wdata & MASK);
        ALIAS_CLR: q <= q & ~wdata;
        default:   q <= q;
      endcase
    end
  end

  assert_put_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && hit && off == '0) |=> (q == $past(wdata & MASK)));
  assert_set_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && hit && off == ADDR_W'(1)) |=> ((q & $past(wdata & MASK)) == $past(wdata & MASK)));
  assert_clr_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && hit && off == ADDR_W'(2)) |=> ((q & $past(wdata)) == '0));
  assert_untouched_R11: assert property (@(posedge clk) disable iff (rst)
    (!(wr_en && hit)) |=> $stable(q));
endmodule

// File: rtl/ulpi_rb_event.sv
module ulpi_rb_event
  import ulpi_rb_pkg::*;
#(
  parameter int N = STAT_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] stat_in,
  input  logic [N-1:0] rise_en,
  input  logic [N-1:0] fall_en,
  input  logic         rd_clr,
  output logic [N-1:0] stat_q,
  output logic [N-1:0] latch_q,
  output logic         irq_q,
  output logic         req_q
);
  logic         primed_q;
  logic [N-1:0] ev;
  logic [N-1:0] latch_nxt;

  always_comb begin
    ev = '0;
    if (primed_q)
      ev = (stat_in & ~stat_q & rise_en) | (~stat_in & stat_q & fall_en);
    latch_nxt = (rd_clr ? '0 : latch_q) | ev;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q   <= '0;
      primed_q <= 1'b0;
      latch_q  <= '0;
      irq_q    <= 1'b0;
      req_q    <= 1'b0;
    end else begin
      stat_q   <= stat_in;
      primed_q <= 1'b1;
      latch_q  <= latch_nxt;
      irq_q    <= |latch_nxt;
      req_q    <= |ev;
    end
  end

  assert_req_latched_R7: assert property (@(posedge clk) disable iff (rst)
    req_q |-> (latch_q != '0));
  assert_irq_tracks_R9: assert property (@(posedge clk) disable iff (rst)
    irq_q == (latch_q != '0));
  assert_clear_on_read_R9: assert property (@(posedge clk) disable iff (rst)
    (rd_clr && ev == '0) |=> (latch_q == '0));
  assert_event_wins_R10: assert property (@(posedge clk) disable iff (rst)
    (rd_clr && ev != '0) |=> ((latch_q & $past(ev)) == $past(ev)));
  assert_quiet_start_R12: assert property (@(posedge clk) disable iff (rst)
    $rose(primed_q) |-> !req_q);
endmodule

// File: rtl/ulpi_regbank.sv
module ulpi_regbank
  import ulpi_rb_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID  = 16'hA5C3,
  parameter logic [15:0] PRODUCT_ID = 16'h0F17
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              reg_rd,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [STAT_W-1:0] stat_in,
  output logic              irq_o,
  output logic              rxcmd_req_o
);
  localparam int PAD_W = DATA_W - STAT_W;

  logic [DATA_W-1:0] ctl_q   [NCTL];
  logic [NCTL-1:0]   ctl_hit;
  logic [STAT_W-1:0] stat_q;
  logic [STAT_W-1:0] latch_q;
  logic [DATA_W-1:0] rd_val;
  logic              rd_clr;

  for (genvar i = 0; i < NCTL; i++) begin : g_ctl
    ulpi_rb_alias_reg #(
      .BASE (CTL_BASE[i]),
      .RSTV (CTL_RST[i]),
      .MASK (CTL_MASK[i])
    ) u_reg (
      .clk   (clk),
      .rst   (rst),
      .wr_en (reg_wr),
      .addr  (reg_addr),
      .wdata (reg_wdata),
      .hit   (ctl_hit[i]),
      .q     (ctl_q[i])
    );
  end

  assign rd_clr = reg_rd && (reg_addr == ADR_LATCH);

  ulpi_rb_event #(.N(STAT_W)) u_event (
    .clk     (clk),
    .rst     (rst),
    .stat_in (stat_in),
    .rise_en (ctl_q[IDX_RISE][STAT_W-1:0]),
    .fall_en (ctl_q[IDX_FALL][STAT_W-1:0]),
    .rd_clr  (rd_clr),
    .stat_q  (stat_q),
    .latch_q (latch_q),
    .irq_q   (irq_o),
    .req_q   (rxcmd_req_o)
  );

  always_comb begin
    rd_val = '0;
    case (reg_addr)
      8'h00:     rd_val = VENDOR_ID[7:0];
      8'h01:     rd_val = VENDOR_ID[15:8];
      8'h02:     rd_val = PRODUCT_ID[7:0];
      8'h03:     rd_val = PRODUCT_ID[15:8];
      ADR_STAT:  rd_val = {{PAD_W{1'b0}}, stat_q};
      ADR_LATCH: rd_val = {{PAD_W{1'b0}}, latch_q};
      default:   rd_val = '0;
    endcase
    for (int i = 0; i < NCTL; i++)
      if (ctl_hit[i]) rd_val = ctl_q[i];
  end

  always_ff @(posedge clk) begin
    if (rst)         reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_val;
  end

  assert_rd_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !reg_rd |=> $stable(reg_rdata));
  assert_one_hit_R4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ctl_hit));
  assert_req_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    (rxcmd_req_o && $stable(stat_in)) |=> !rxcmd_req_o);
endmodule

// File: tb/ulpi_regbank_bench.sv
module ulpi_regbank_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] VID = 16'hA5C3;
  localparam logic [15:0] PID = 16'h0F17;
  localparam int NV = 37;
  localparam logic OP_W = 1'b0;
  localparam logic OP_R = 1'b1;

  // {op, addr, data, requirement number}
  localparam logic [20:0] VEC [NV] = '{
    {OP_R, 8'h04, 8'h41, 4'd1},   // R1 reset values
    {OP_R, 8'h07, 8'h00, 4'd1},
    {OP_R, 8'h0A, 8'h06, 4'd1},
    {OP_R, 8'h0D, 8'h1F, 4'd1},
    {OP_R, 8'h10, 8'h1F, 4'd1},
    {OP_R, 8'h14, 8'h00, 4'd1},
    {OP_W, 8'h04, 8'hFF, 4'd2},   // R2 reserved bit 7
    {OP_R, 8'h04, 8'h7F, 4'd2},
    {OP_W, 8'h06, 8'h0F, 4'd3},   // R3 clear alias
    {OP_R, 8'h05, 8'h70, 4'd4},   // R4 read via set alias
    {OP_W, 8'h05, 8'h81, 4'd3},
    {OP_R, 8'h06, 8'h71, 4'd4},
    {OP_W, 8'h07, 8'hA5, 4'd2},
    {OP_R, 8'h08, 8'hA5, 4'd4},
    {OP_W, 8'h09, 8'h05, 4'd3},
    {OP_R, 8'h07, 8'hA0, 4'd3},
    {OP_W, 8'h0B, 8'h01, 4'd3},
    {OP_R, 8'h0C, 8'h07, 4'd4},
    {OP_W, 8'h0D, 8'hFF, 4'd2},
    {OP_R, 8'h0F, 8'h1F, 4'd2},
    {OP_W, 8'h12, 8'h03, 4'd3},
    {OP_R, 8'h10, 8'h1C, 4'd3},
    {OP_R, 8'h00, 8'hC3, 4'd5},   // R5 identification
    {OP_R, 8'h01, 8'hA5, 4'd5},
    {OP_R, 8'h02, 8'h17, 4'd5},
    {OP_R, 8'h03, 8'h0F, 4'd5},
    {OP_W, 8'h00, 8'hFF, 4'd5},
    {OP_R, 8'h00, 8'hC3, 4'd5},
    {OP_W, 8'h20, 8'h55, 4'd11},  // R11 unassigned space
    {OP_R, 8'h20, 8'h00, 4'd11},
    {OP_W, 8'h2F, 8'h12, 4'd11},
    {OP_R, 8'h2F, 8'h00, 4'd11},
    {OP_R, 8'h40, 8'h00, 4'd11},
    {OP_W, 8'h13, 8'hFF, 4'd6},   // R6 status read-only
    {OP_R, 8'h13, 8'h05, 4'd6},
    {OP_W, 8'h14, 8'hFF, 4'd9},   // R9 latch not writable
    {OP_R, 8'h14, 8'h00, 4'd9}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] reg_addr = '0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic       reg_rd = 1'b0;
  logic [7:0] reg_rdata;
  logic [4:0] stat_in = 5'b00101;
  logic       irq_o;
  logic       rxcmd_req_o;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ulpi_regbank #(.VENDOR_ID(VID), .PRODUCT_ID(PID)) u_ulpi_regbank (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rd(reg_rd), .reg_rdata(reg_rdata), .stat_in(stat_in), .irq_o(irq_o),
    .rxcmd_req_o(rxcmd_req_o)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000 && !done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic do_read(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1'b1;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 rdata after reset", reg_rdata, 8'h00);
    check("R12 no request with inputs high at start", {7'd0, rxcmd_req_o}, 8'h00);
    @(negedge clk);
    check("R12 no irq with inputs high at start", {7'd0, irq_o}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][20] == OP_W) do_write(VEC[i][19:12], VEC[i][11:4]);
      else begin
        do_read(VEC[i][19:12], v);
        check($sformatf("R%0d table read %02h", VEC[i][3:0], VEC[i][19:12]), v, VEC[i][11:4]);
      end
    end

    // R4: rdata holds between reads
    repeat (3) @(negedge clk);
    check("R4 rdata held", reg_rdata, 8'h00);

    // R7: rising edge on bit 3
    @(negedge clk); stat_in[3] = 1'b1;
    @(negedge clk);
    check("R7 rise request", {7'd0, rxcmd_req_o}, 8'h01);
    check("R9 irq set", {7'd0, irq_o}, 8'h01);
    @(negedge clk);
    check("R7 request one cycle", {7'd0, rxcmd_req_o}, 8'h00);
    do_read(8'h14, v); check("R9 latch value", v, 8'h08);
    check("R9 irq cleared by read", {7'd0, irq_o}, 8'h00);
    do_read(8'h14, v); check("R9 latch cleared", v, 8'h00);

    // R8: falling enable bit 0 is clear (1Ch)
    @(negedge clk); stat_in[0] = 1'b0;
    @(negedge clk);
    check("R8 no request disabled fall", {7'd0, rxcmd_req_o}, 8'h00);
    do_read(8'h14, v); check("R8 no latch disabled fall", v, 8'h00);

    // R7: enabled falling edge on bit 2
    @(negedge clk); stat_in[2] = 1'b0;
    @(negedge clk);
    check("R7 fall request", {7'd0, rxcmd_req_o}, 8'h01);

    // R10: event on bit 4 at the same edge as the latch read
    @(negedge clk); reg_addr = 8'h14; reg_rd = 1'b1; stat_in[4] = 1'b1;
    @(negedge clk); reg_rd = 1'b0;
    check("R10 read returns old latch", reg_rdata, 8'h04);
    check("R10 irq stays high", {7'd0, irq_o}, 8'h01);
    do_read(8'h14, v); check("R10 new event kept", v, 8'h10);

    // R8: rising enable bit 1 cleared via clear alias
    do_write(8'h0F, 8'h02);
    @(negedge clk); stat_in[1] = 1'b1;
    @(negedge clk);
    check("R8 no request disabled rise", {7'd0, rxcmd_req_o}, 8'h00);
    do_read(8'h14, v); check("R8 latch empty", v, 8'h00);
    do_read(8'h13, v); check("R6 live status", v, 8'h1A);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule